// File: doc/BRIEF.md
# Audio Input Buffer Request Controller

This block sits beside five audio input FIFOs and decides when each of them should be refilled. It keeps a word count for every FIFO: a push on the channel's input stream raises the count, and a pop from the downstream mixer lowers it. From that count it derives the free space. Each channel has a 4-bit threshold field. The channel is ready for a refill when its free space is at least the threshold plus one.

For every channel, two refill signals go out. The first is a plain level toward a waveform source. The second is a request/acknowledge handshake toward a DMA engine. After an acknowledge, the DMA side is locked until the block has counted a burst of threshold-plus-one words. Words that arrive on a DMA-enabled channel outside a burst are treated as over-delivery. A bank of sticky interrupt status bits, with per-bit enables and write-one-to-clear controls, reports four sources per channel: refill ready, overflow, DMA over-delivery and external bus error.

The input stream follows valid/ready rules. `in_ready` is high while the FIFO has room, and a beat is taken when `in_valid` and `in_ready` are both high. A source that honours ready never loses data. A beat offered while `in_ready` is low is discarded and flagged as an overflow; it is not held.

Top module: `audio_req_ctrl`

## Requirements
- R1: After reset, `dma_req`, `wfg_req`, `irq_status` and `irq` are all zero, and `in_ready` is high on every channel because every FIFO starts empty.
- R2: With its DMA enable set, a channel raises `dma_req[c]` one clock edge after its free space (16 minus occupancy) is found to be at least its threshold plus one. While the free space is below that amount, `dma_req[c]` stays low. Channel c uses threshold bits [4c+3:4c], and bit c of each 5-bit bus belongs to channel c.
- R3: An acknowledge on `dma_ack[c]` while `dma_req[c]` is high lowers the request at the next edge.
- R4: After an acknowledge, the burst length is latched as threshold plus one. No new request is raised until that many words have been accepted, and a new request can appear at the earliest one edge after the last word.
- R5: A word that arrives on a DMA-enabled channel while no burst is in progress sets DMA-error status bit 10+c. Channels with DMA disabled never set it.
- R6: `wfg_req[c]` is high, in the same cycle, exactly when the waveform enable is set and the free space is at least threshold plus one.
- R7: A beat offered while the FIFO holds 16 words is dropped: the occupancy does not change. Overflow status bit 5+c is set at the next edge.
- R8: A one-cycle pulse on `bus_err[c]` sets bus-error status bit 15+c at the next edge.
- R9: Status bits are sticky. A one on the matching `irq_clr` bit clears a status bit at the next edge. If a set event and a clear arrive in the same cycle, the set wins.
- R10: `irq` is the OR of all status bits whose `irq_en` bit is also set. It follows the status register without a further delay.
- R11: Clearing `cfg_dma_en[c]` drops the request and abandons any burst in progress at the next edge.
- R12: Refill-ready status bit c is set at every edge where channel c has at least threshold plus one words free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Per-channel input beat offered |
| in_ready | output | 5 | Per-channel FIFO has room |
| out_pop | input | 5 | Per-channel word consumed by the mixer (ignored when the FIFO is empty) |
| cfg_thresh | input | 20 | Per-channel 4-bit free-space threshold |
| cfg_dma_en | input | 5 | Per-channel DMA request enable |
| cfg_wfg_en | input | 5 | Per-channel waveform-source level enable |
| dma_req | output | 5 | DMA request per channel |
| dma_ack | input | 5 | DMA acknowledge per channel |
| wfg_req | output | 5 | Waveform-source ready level per channel |
| bus_err | input | 5 | External error-response pulse per channel |
| irq_en | input | 20 | Interrupt enables, bit = source*5 + channel |
| irq_clr | input | 20 | Write-one-to-clear strobes, same layout |
| irq_status | output | 20 | Sticky status (source 0 ready, 1 overflow, 2 DMA error, 3 bus error) |
| irq | output | 1 | Combined interrupt |

## Verification
`dma_req`, `irq_status` and the occupancy behind `in_ready` are registered, so each of them answers one rising edge after the stimulus that causes it. A request that follows the end of a burst needs two edges: one to return to idle and one to raise the request. `wfg_req`, `in_ready` and `irq` are combinational from that state and from the configuration, so they follow a configuration change within the same cycle. The bench drives all inputs 2 ns after a rising edge and samples 2 ns after the following edge, or 1 ns after a configuration change when it checks a combinational output. It then compares against the edge count worked out for each case.

// File: rtl/audio_req_pkg.sv
package audio_req_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_XFER = 2'd2
  } seq_state_e;

  localparam int SRC_READY = 0;
  localparam int SRC_OVF   = 1;
  localparam int SRC_DERR  = 2;
  localparam int SRC_BERR  = 3;
  localparam int NSRC      = 4;
endpackage

// File: rtl/chan_occupancy.sv
module chan_occupancy #(
  parameter int DEPTH = 16,
  parameter int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_try,
  input  logic             pop_try,
  output logic [OCC_W-1:0] free_words,
  output logic             full,
  output logic             accepted,
  output logic             ovf_evt
);
  logic [OCC_W-1:0] occ_q;
  logic             pop_ok;

  assign full       = (occ_q == OCC_W'(DEPTH));
  assign accepted   = push_try && !full;
  assign ovf_evt    = push_try && full;
  assign pop_ok     = pop_try && (occ_q != '0);
  assign free_words = OCC_W'(DEPTH) - occ_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q <= '0;
    end else begin
      case ({accepted, pop_ok})
        2'b10:   occ_q <= occ_q + OCC_W'(1);
        2'b01:   occ_q <= occ_q - OCC_W'(1);
        default: occ_q <= occ_q;
      endcase
    end
  end
endmodule

// File: rtl/chan_dma_seq.sv
module chan_dma_seq
  import audio_req_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_en,
  input  logic          room_ok,
  input  logic [CW-1:0] burst_len,
  input  logic          ack,
  input  logic          word_in,
  output logic          req,
  output logic          xfer_err
);
  seq_state_e    state_q;
  logic [CW-1:0] len_q;
  logic [CW-1:0] cnt_q;

  assign req      = (state_q == SEQ_REQ);
  assign xfer_err = dma_en && word_in && (state_q != SEQ_XFER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      len_q   <= '0;
      cnt_q   <= '0;
    end else if (!dma_en) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (room_ok) state_q <= SEQ_REQ;
        SEQ_REQ: begin
          if (ack) begin
            state_q <= SEQ_XFER;
            len_q   <= burst_len;
            cnt_q   <= '0;
          end
        end
        SEQ_XFER: begin
          if (word_in) begin
            if (cnt_q + CW'(1) == len_q) begin
              state_q <= SEQ_IDLE;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int NB = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set_evt,
  input  logic [NB-1:0] clr,
  input  logic [NB-1:0] en,
  output logic [NB-1:0] status,
  output logic          irq
);
  logic [NB-1:0] status_q;

  assign status = status_q;
  assign irq    = |(status_q & en);

  for (genvar i = 0; i < NB; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)          status_q[i] <= 1'b0;
      else if (set_evt[i]) status_q[i] <= 1'b1;
      else if (clr[i])     status_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/audio_req_ctrl.sv
module audio_req_ctrl
  import audio_req_pkg::*;
#(
  parameter int NCH   = 5,
  parameter int DEPTH = 16,
  parameter int TH_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       in_valid,
  output logic [NCH-1:0]       in_ready,
  input  logic [NCH-1:0]       out_pop,
  input  logic [NCH*TH_W-1:0]  cfg_thresh,
  input  logic [NCH-1:0]       cfg_dma_en,
  input  logic [NCH-1:0]       cfg_wfg_en,
  output logic [NCH-1:0]       dma_req,
  input  logic [NCH-1:0]       dma_ack,
  output logic [NCH-1:0]       wfg_req,
  input  logic [NCH-1:0]       bus_err,
  input  logic [NSRC*NCH-1:0]  irq_en,
  input  logic [NSRC*NCH-1:0]  irq_clr,
  output logic [NSRC*NCH-1:0]  irq_status,
  output logic                 irq
);
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam int CW    = ((OCC_W > TH_W) ? OCC_W : TH_W) + 1;
  localparam int NB    = NSRC * NCH;

  logic [NCH-1:0] room_ok;
  logic [NCH-1:0] ovf_evt;
  logic [NCH-1:0] derr_evt;
  logic [NB-1:0]  set_evt;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [OCC_W-1:0] free_words;
    logic             full;
    logic             accepted;
    logic [CW-1:0]    need;

    assign need       = CW'(cfg_thresh[c*TH_W +: TH_W]) + CW'(1);
    assign room_ok[c] = (CW'(free_words) >= need);
    assign in_ready[c] = !full;
    assign wfg_req[c]  = cfg_wfg_en[c] && room_ok[c];

    chan_occupancy #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_occ (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_try   (in_valid[c]),
      .pop_try    (out_pop[c]),
      .free_words (free_words),
      .full       (full),
      .accepted   (accepted),
      .ovf_evt    (ovf_evt[c])
    );

    chan_dma_seq #(.CW(CW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .dma_en    (cfg_dma_en[c]),
      .room_ok   (room_ok[c]),
      .burst_len (need),
      .ack       (dma_ack[c]),
      .word_in   (in_valid[c]),
      .req       (dma_req[c]),
      .xfer_err  (derr_evt[c])
    );
  end

  assign set_evt = {bus_err, derr_evt, ovf_evt, room_ok};

  irq_bank #(.NB(NB)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (set_evt),
    .clr     (irq_clr),
    .en      (irq_en),
    .status  (irq_status),
    .irq     (irq)
  );
endmodule

// File: rtl/audio_req_ctrl_chk.sv
module audio_req_ctrl_chk #(
  parameter int NCH = 5,
  parameter int NB  = 20
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] in_valid,
  input logic [NCH-1:0] in_ready,
  input logic [NCH-1:0] cfg_dma_en,
  input logic [NCH-1:0] dma_req,
  input logic [NCH-1:0] dma_ack,
  input logic [NCH-1:0] bus_err,
  input logic [NB-1:0]  irq_clr,
  input logic [NB-1:0]  irq_status
);
  for (genvar c = 0; c < NCH; c++) begin : g_c
    assert_ack_drops_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req[c] && dma_ack[c] |=> !dma_req[c]);
    assert_abort_on_disable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_dma_en[c] |=> !dma_req[c]);
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid[c] && !in_ready[c] |=> irq_status[NCH + c]);
    assert_bus_err_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err[c] |=> irq_status[3*NCH + c]);
  end
  for (genvar i = 0; i < NB; i++) begin : g_b
    assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_status[i] && !irq_clr[i] |=> irq_status[i]);
  end
endmodule

bind audio_req_ctrl audio_req_ctrl_chk #(.NCH(NCH), .NB(4*NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .cfg_dma_en (cfg_dma_en),
  .dma_req    (dma_req),
  .dma_ack    (dma_ack),
  .bus_err    (bus_err),
  .irq_clr    (irq_clr),
  .irq_status (irq_status)
);

// File: tb/audio_req_ctrl_tb.sv
module audio_req_ctrl_tb;
  localparam int NCH = 5;
  localparam int NB  = 20;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] in_valid, in_ready, out_pop, cfg_dma_en, cfg_wfg_en;
  logic [NCH-1:0] dma_req, dma_ack, wfg_req, bus_err;
  logic [19:0]    cfg_thresh;
  logic [NB-1:0]  irq_en, irq_clr, irq_status;
  logic           irq;
  int             n_tests = 0;
  int             n_fail  = 0;

  always #4 clk = ~clk;

  audio_req_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_pop(out_pop), .cfg_thresh(cfg_thresh), .cfg_dma_en(cfg_dma_en),
    .cfg_wfg_en(cfg_wfg_en), .dma_req(dma_req), .dma_ack(dma_ack),
    .wfg_req(wfg_req), .bus_err(bus_err), .irq_en(irq_en), .irq_clr(irq_clr),
    .irq_status(irq_status), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_n(input int ch, input int n);
    in_valid[ch] = 1'b1;
    repeat (n) tick();
    in_valid[ch] = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "dma_req", 32'(dma_req), 0);
    chk("R1", "wfg_req", 32'(wfg_req), 0);
    chk("R1", "in_ready", 32'(in_ready), 32'h1f);
    chk("R1", "irq_status", 32'(irq_status), 0);
    chk("R1", "irq", 32'(irq), 0);
  endtask

  task automatic t_dma_burst();
    cfg_thresh[3:0] = 4'd3;
    cfg_dma_en[0] = 1'b1;
    tick();
    chk("R2", "req after room", 32'(dma_req[0]), 1);
    chk("R12", "ready status ch0", 32'(irq_status[0]), 1);
    dma_ack[0] = 1'b1; tick(); dma_ack[0] = 1'b0;
    chk("R3", "req after ack", 32'(dma_req[0]), 0);
    in_valid[0] = 1'b1;
    repeat (3) tick();
    chk("R4", "req locked mid-burst", 32'(dma_req[0]), 0);
    tick();
    in_valid[0] = 1'b0;
    chk("R4", "req at burst end", 32'(dma_req[0]), 0);
    chk("R5", "no error in burst", 32'(irq_status[10]), 0);
    tick();
    chk("R4", "req re-armed", 32'(dma_req[0]), 1);
    dma_ack[0] = 1'b1; tick(); dma_ack[0] = 1'b0;
    push_n(0, 5);
    chk("R5", "extra word error", 32'(irq_status[10]), 1);
    chk("R2", "req after extra", 32'(dma_req[0]), 1);
    cfg_dma_en[0] = 1'b0;
    tick();
    chk("R11", "req after disable", 32'(dma_req[0]), 0);
  endtask

  task automatic t_threshold();
    cfg_thresh[7:4] = 4'd15;
    push_n(1, 1);
    cfg_dma_en[1] = 1'b1;
    tick(); tick();
    chk("R2", "below threshold", 32'(dma_req[1]), 0);
    out_pop[1] = 1'b1; tick(); out_pop[1] = 1'b0;
    chk("R2", "edge after pop", 32'(dma_req[1]), 0);
    tick();
    chk("R2", "full room request", 32'(dma_req[1]), 1);
    cfg_dma_en[1] = 1'b0;
    tick();
  endtask

  task automatic t_wfg();
    cfg_thresh[11:8] = 4'd7;
    cfg_wfg_en[2] = 1'b1;
    #1;
    chk("R6", "wfg empty", 32'(wfg_req[2]), 1);
    push_n(2, 9);
    chk("R6", "wfg free 7", 32'(wfg_req[2]), 0);
    out_pop[2] = 1'b1; tick(); out_pop[2] = 1'b0;
    chk("R6", "wfg free 8", 32'(wfg_req[2]), 1);
    cfg_wfg_en[2] = 1'b0;
    #1;
    chk("R6", "wfg disabled", 32'(wfg_req[2]), 0);
    chk("R5", "no error without dma", 32'(irq_status[12]), 0);
  endtask

  task automatic t_overflow();
    push_n(3, 16);
    chk("R7", "ready when full", 32'(in_ready[3]), 0);
    chk("R7", "no ovf yet", 32'(irq_status[8]), 0);
    push_n(3, 1);
    chk("R7", "ovf flagged", 32'(irq_status[8]), 1);
    cfg_thresh[15:12] = 4'd15;
    cfg_wfg_en[3] = 1'b1;
    out_pop[3] = 1'b1;
    repeat (16) tick();
    out_pop[3] = 1'b0;
    chk("R7", "dropped word not counted", 32'(wfg_req[3]), 1);
    chk("R7", "ready after drain", 32'(in_ready[3]), 1);
    cfg_wfg_en[3] = 1'b0;
  endtask

  task automatic t_irq();
    chk("R8", "bus err idle", 32'(irq_status[19]), 0);
    bus_err[4] = 1'b1; tick(); bus_err[4] = 1'b0;
    chk("R8", "bus err set", 32'(irq_status[19]), 1);
    tick();
    chk("R9", "sticky", 32'(irq_status[19]), 1);
    irq_en = 20'h80000;
    #1;
    chk("R10", "irq enabled", 32'(irq), 1);
    irq_clr[19] = 1'b1; bus_err[4] = 1'b1; tick(); bus_err[4] = 1'b0;
    chk("R9", "set wins over clear", 32'(irq_status[19]), 1);
    tick();
    irq_clr[19] = 1'b0;
    chk("R9", "cleared", 32'(irq_status[19]), 0);
    #1;
    chk("R10", "irq masked others", 32'(irq), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = '0; out_pop = '0; cfg_dma_en = '0; cfg_wfg_en = '0;
    dma_ack = '0; bus_err = '0; cfg_thresh = '0; irq_en = '0; irq_clr = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    t_reset();
    t_dma_burst();
    t_threshold();
    t_wfg();
    t_overflow();
    t_irq();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule